// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational 32-bit arithmetic and logic unit. It takes two operands and a 3-bit operation code. It produces a 32-bit result and three flags: zero, signed overflow and carry-out. It performs bitwise AND, bitwise OR, addition, subtraction and a signed less-than comparison.

The datapath is a row of identical one-bit slices joined by a ripple carry chain, and a dedicated most significant slice sits at the top of the row. The top bit of the operation code has a second role. It inverts the second operand in every slice, and it also serves as the carry into bit 0, which turns the adder into a two's-complement subtractor.

The comparison reuses the subtractor. The most significant slice corrects the sign of the difference for overflow. That corrected sign is fed back into the "less" input of bit 0, and the less inputs of all other slices are tied low.

Top module: `slice_alu`

## Requirements
- R1: Operation code 3'b000 gives result = opa AND opb, bit by bit.
- R2: Operation code 3'b001 gives result = opa OR opb, bit by bit.
- R3: Operation code 3'b010 gives result = (opa + opb) mod 2^32, and carry_out equals the carry leaving bit 31 of that sum.
- R4: Operation code 3'b110 gives result = (opa - opb) mod 2^32, formed as opa + ~opb + 1. Its carry_out is the carry leaving bit 31, which is 1 exactly when opa >= opb as unsigned numbers.
- R5: overflow is 1 only for codes 3'b010 and 3'b110, and only when the two's-complement result of that add or subtract does not fit in 32 signed bits. Every other code drives overflow to 0.
- R6: Operation code 3'b111 gives result bit 0 = 1 when opa < opb as signed 32-bit numbers, and result bits 31..1 = 0. The comparison is also correct when opa - opb overflows.
- R7: zero is 1 exactly when all 32 result bits are 0, for every operation code.
- R8: The unassigned codes 3'b011, 3'b100 and 3'b101 give result 0, zero 1, overflow 0 and carry_out 0.
- R9: carry_out is 0 for codes 3'b000, 3'b001 and 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 3 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (inverted internally for subtract and compare) |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry leaving the most significant slice for add or subtract |

## Verification
The block has no registers, so every output is due in the same cycle as the operands and code that produce it, after the ripple carry settles. The bench applies each new vector on the falling clock edge. It samples all four outputs two nanoseconds later, which is still before the next rising edge, so no result is read while its inputs are changing. Directed vectors cover the overflow boundaries, compares that overflow and the unassigned codes. A fixed-seed random run then covers all eight codes.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    localparam logic [2:0] OPC_AND = 3'b000;
    localparam logic [2:0] OPC_OR  = 3'b001;
    localparam logic [2:0] OPC_ADD = 3'b010;
    localparam logic [2:0] OPC_SUB = 3'b110;
    localparam logic [2:0] OPC_SLT = 3'b111;

    typedef enum logic [1:0] {
        PICK_AND  = 2'd0,
        PICK_OR   = 2'd1,
        PICK_SUM  = 2'd2,
        PICK_LESS = 2'd3
    } pick_t;

    typedef struct packed {
        logic  legal;
        logic  neg_b;
        logic  arith_flags;
        pick_t pick;
    } ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_slice_pkg::*;
(
    input  logic [2:0] op,
    output ctrl_t      ctrl
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d.legal       = 1'b1;
        ctrl_d.neg_b       = op[2];
        ctrl_d.arith_flags = 1'b0;
        ctrl_d.pick        = PICK_AND;
        case (op)
            OPC_AND: ctrl_d.pick = PICK_AND;
            OPC_OR:  ctrl_d.pick = PICK_OR;
            OPC_ADD: begin
                ctrl_d.pick        = PICK_SUM;
                ctrl_d.arith_flags = 1'b1;
            end
            OPC_SUB: begin
                ctrl_d.pick        = PICK_SUM;
                ctrl_d.arith_flags = 1'b1;
            end
            OPC_SLT: ctrl_d.pick = PICK_LESS;
            default: begin
                ctrl_d.legal = 1'b0;
                ctrl_d.neg_b = 1'b0;
            end
        endcase
    end

    assign ctrl = ctrl_d;
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_slice_pkg::*;
(
    input  logic  a,
    input  logic  b,
    input  logic  neg_b,
    input  logic  cin,
    input  logic  less,
    input  pick_t pick,
    output logic  sum,
    output logic  res,
    output logic  cout
);
    logic b_eff;

    always_comb begin
        b_eff = b ^ neg_b;
        sum   = a ^ b_eff ^ cin;
        cout  = (a & b_eff) | (a & cin) | (b_eff & cin);
        case (pick)
            PICK_AND:  res = a & b_eff;
            PICK_OR:   res = a | b_eff;
            PICK_SUM:  res = sum;
            default:   res = less;
        endcase
    end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
    import alu_slice_pkg::*;
(
    input  logic  a,
    input  logic  b,
    input  logic  neg_b,
    input  logic  cin,
    input  pick_t pick,
    output logic  res,
    output logic  cout,
    output logic  set_out,
    output logic  ovf_out
);
    logic sum_top;

    alu_bit_slice u_bit (
        .a     (a),
        .b     (b),
        .neg_b (neg_b),
        .cin   (cin),
        .less  (1'b0),
        .pick  (pick),
        .sum   (sum_top),
        .res   (res),
        .cout  (cout)
    );

    always_comb begin
        ovf_out = cin ^ cout;
        set_out = sum_top ^ ovf_out;
    end
endmodule

// File: rtl/alu_zero_flag.sv
module alu_zero_flag #(
    parameter int W = 32
) (
    input  logic [W-1:0] v,
    output logic         z
);
    assign z = ~|v;
endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import alu_slice_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   alu_op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result,
    output logic         zero,
    output logic         overflow,
    output logic         carry_out
);
    localparam int TOP = W - 1;

    typedef struct packed {
        logic [W-1:0] result;
        logic         ovf;
        logic         carry;
    } out_t;

    ctrl_t        ctrl;
    logic [W:0]   carry;
    logic [W-1:0] raw;
    logic [W-1:0] sums;
    logic         set_top;
    logic         ovf_top;
    out_t         out_d;

    alu_op_decode u_dec (
        .op   (alu_op),
        .ctrl (ctrl)
    );

    assign carry[0] = ctrl.neg_b;

    generate
        for (genvar i = 0; i < TOP; i++) begin : g_low
            alu_bit_slice u_slice (
                .a     (opa[i]),
                .b     (opb[i]),
                .neg_b (ctrl.neg_b),
                .cin   (carry[i]),
                .less  ((i == 0) ? set_top : 1'b0),
                .pick  (ctrl.pick),
                .sum   (sums[i]),
                .res   (raw[i]),
                .cout  (carry[i+1])
            );
        end
    endgenerate

    assign sums[TOP] = 1'b0;

    alu_msb_slice u_msb (
        .a       (opa[TOP]),
        .b       (opb[TOP]),
        .neg_b   (ctrl.neg_b),
        .cin     (carry[TOP]),
        .pick    (ctrl.pick),
        .res     (raw[TOP]),
        .cout    (carry[W]),
        .set_out (set_top),
        .ovf_out (ovf_top)
    );

    always_comb begin
        out_d.result = ctrl.legal ? raw : '0;
        out_d.ovf    = ctrl.legal & ctrl.arith_flags & ovf_top;
        out_d.carry  = ctrl.legal & ctrl.arith_flags & carry[W];
    end

    assign result    = out_d.result;
    assign overflow  = out_d.ovf;
    assign carry_out = out_d.carry;

    alu_zero_flag #(.W(W)) u_zero (
        .v (out_d.result),
        .z (zero)
    );

    logic [W:0] chk_add;
    always_comb begin
        chk_add = {1'b0, opa} + {1'b0, opb};
        if (alu_op == OPC_ADD) begin
            assert_add_sum_R3: assert ({carry_out, result} == chk_add)
                else $error("add result mismatch");
        end
        if (alu_op == OPC_SLT) begin
            assert_slt_upper_R6: assert (result[W-1:1] == '0)
                else $error("compare upper bits not clear");
        end
        if (alu_op != OPC_ADD && alu_op != OPC_SUB) begin
            assert_no_overflow_R5: assert (!overflow)
                else $error("overflow outside add/sub");
        end
        if (alu_op == 3'b011 || alu_op == 3'b100 || alu_op == 3'b101) begin
            assert_undef_quiet_R8: assert (result == '0 && zero && !carry_out)
                else $error("unassigned code not quiet");
        end
        assert_zero_flag_R7: assert (zero == (result == '0))
            else $error("zero flag mismatch");
    end
endmodule

// File: tb/slice_alu_test.sv
`timescale 1ns/1ps
module slice_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  alu_op = 3'b000;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        zero, overflow, carry_out;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    slice_alu uut (
        .alu_op(alu_op), .opa(opa), .opb(opb),
        .result(result), .zero(zero), .overflow(overflow), .carry_out(carry_out)
    );

    function automatic logic [34:0] ref_alu(input logic [2:0] op,
                                            input logic [31:0] a,
                                            input logic [31:0] b);
        logic [32:0] s;
        logic [31:0] r;
        logic        v, c;
        r = '0; v = 1'b0; c = 1'b0;
        case (op)
            3'b000: r = a & b;
            3'b001: r = a | b;
            3'b010: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[31:0]; c = s[32];
                v = (a[31] == b[31]) && (s[31] != a[31]);
            end
            3'b110: begin
                s = {1'b0, a} + {1'b0, ~b} + 33'd1;
                r = s[31:0]; c = s[32];
                v = (a[31] != b[31]) && (s[31] != a[31]);
            end
            3'b111: r = {31'd0, ($signed(a) < $signed(b))};
            default: r = '0;
        endcase
        return {r, (r == 32'd0), v, c};
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b110: return "R4";
            3'b111: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic apply_check(input logic [2:0] op, input logic [31:0] a,
                               input logic [31:0] b);
        logic [34:0] e;
        @(negedge clk);
        alu_op = op; opa = a; opb = b;
        #2;
        e = ref_alu(op, a, b);
        total++;
        if (result !== e[34:3]) begin
            bad++;
            $display("FAIL %s result op=%b a=%h b=%h got=%h exp=%h",
                     tag_of(op), op, a, b, result, e[34:3]);
        end
        total++;
        if (zero !== e[2]) begin
            bad++;
            $display("FAIL R7 zero op=%b got=%b exp=%b", op, zero, e[2]);
        end
        total++;
        if (overflow !== e[1]) begin
            bad++;
            $display("FAIL R5 overflow op=%b a=%h b=%h got=%b exp=%b",
                     op, a, b, overflow, e[1]);
        end
        total++;
        if (carry_out !== e[0]) begin
            bad++;
            $display("FAIL %s carry op=%b a=%h b=%h got=%b exp=%b",
                     (op == 3'b010) ? "R3" : (op == 3'b110) ? "R4" : "R9",
                     op, a, b, carry_out, e[0]);
        end
    endtask

    initial begin
        #150000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0123));
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // idle state: code 000, operands zero -> result 0, zero 1 (R1, R7)
        apply_check(3'b000, 32'h0, 32'h0);
        // R1 / R2 logic patterns
        apply_check(3'b000, 32'hF0F0_A5A5, 32'hFF00_0F0F);
        apply_check(3'b001, 32'hF0F0_0000, 32'h000F_1234);
        // R3 carry out and signed overflow boundaries
        apply_check(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
        apply_check(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
        apply_check(3'b010, 32'h8000_0000, 32'h8000_0000);
        // R4 borrow and overflow boundaries
        apply_check(3'b110, 32'h0000_0005, 32'h0000_0005);
        apply_check(3'b110, 32'h0000_0003, 32'h0000_0007);
        apply_check(3'b110, 32'h8000_0000, 32'h0000_0001);
        // R6 compare, including overflowing differences
        apply_check(3'b111, 32'h8000_0000, 32'h7FFF_FFFF);
        apply_check(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
        apply_check(3'b111, 32'hFFFF_FFFF, 32'h0000_0000);
        apply_check(3'b111, 32'h0000_1234, 32'h0000_1234);
        // R8 unassigned codes with operands that would otherwise be nonzero
        apply_check(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply_check(3'b100, 32'h1234_5678, 32'h0000_0001);
        apply_check(3'b101, 32'h8000_0000, 32'h8000_0000);
        // random mix over all codes
        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  op;
            logic [31:0] a, b;
            op = 3'($urandom());
            a  = $urandom();
            b  = $urandom();
            if (i % 5 == 0) b = a;
            if (i % 7 == 0) a = {a[31], 31'h7FFF_FFF0 | a[30:0]};
            apply_check(op, a, b);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule